// File: doc/BRIEF.md
# Cluster-level coherence directory controller

This block is the home-side directory engine of a two-level coherence scheme. Inside each cluster a snooping bus keeps the caches coherent, so the directory records only which remote clusters hold a block. Each directory entry has a three-value state (uncached-remote, shared-remote, dirty-remote) and a full presence vector with one bit per cluster. The home cluster's own copies are never recorded. A block that is dirty inside the home cluster therefore reads as uncached-remote, and a dirty-remote entry always means that the remote copy really is modified.

Requests arrive on a valid/ready port. Each request carries a kind, the cluster that sent it, the entry index and an auxiliary cluster field. The kinds are Read, Read-Exclusive and Writeback, plus the two notices that an owner cluster returns after a forwarded request: a sharing writeback and a dirty transfer. For each accepted request the block updates the entry and then emits its outgoing messages on a valid/ready message port, one per cycle. The possible messages are a shared-data reply, an exclusive-data reply carrying an acknowledgement count, a forwarded read, a forwarded read-exclusive, an invalidate and an acknowledge. The request port stays closed until every message of the current request has been taken.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every entry is uncached-remote with an empty vector, `msg_valid` is low and `req_ready` is high.
- R2: A Read (`req_type` 0) to an entry that is not dirty-remote yields one shared-data reply (`msg_type` 0) to the requester. A remote requester's bit is then set and the entry becomes shared-remote. A Read from the home cluster leaves the entry unchanged.
- R3: A Read to a dirty-remote entry yields a forwarded read (`msg_type` 3'd2) to the owner, which is the single cluster in the vector, with `msg_aux` holding the requester. The entry is unchanged.
- R4: A sharing writeback (`req_type` 3) sent by the owner of a dirty-remote entry makes the entry shared-remote. The old vector is kept and the cluster in `req_aux` is added to it, unless that cluster is the home cluster. No message is emitted.
- R5: A Read-Exclusive (`req_type` 1) from a remote cluster to an uncached-remote entry yields an exclusive-data reply (`msg_type` 1) with count 0. The entry becomes dirty-remote, with only the requester in the vector.
- R6: A Read-Exclusive to a shared-remote entry first yields an exclusive-data reply whose count is the number of vector members other than the requester. It then yields one invalidate (`msg_type` 4) to each of those members, in ascending cluster index. Afterwards the entry is dirty-remote with only the requester in the vector, or uncached-remote and empty if the requester is the home cluster.
- R7: A Read-Exclusive to a dirty-remote entry yields a forwarded read-exclusive (`msg_type` 3'd3) to the owner, with `msg_aux` holding the requester. A dirty transfer (`req_type` 4) sent by the owner yields an acknowledge (`msg_type` 5) to the cluster in `req_aux`, which becomes the sole dirty owner. If that cluster is the home cluster, the entry becomes uncached-remote and empty instead.
- R8: A Read-Exclusive from the home cluster to an uncached-remote entry yields an exclusive-data reply with count 0 and leaves the entry uncached-remote and empty.
- R9: A Writeback (`req_type` 2) sent by the owner of a dirty-remote entry makes the entry uncached-remote and empty, without a message. A Writeback, sharing writeback or dirty transfer that is not sent by the owner of a dirty-remote entry, and any `req_type` of 5 to 7, emits nothing and leaves the entry unchanged.
- R10: At most one message is offered at a time. A message that is not taken holds all its fields. `req_ready` is low from the cycle after acceptance until the last message of that request has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request port open |
| req_type | input | 3 | Request kind: 0 read, 1 read-exclusive, 2 writeback, 3 sharing writeback, 4 dirty transfer |
| req_src | input | CW | Cluster that sent the request |
| req_aux | input | CW | Original requester, carried by the two owner notices |
| req_addr | input | AW | Directory entry index |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_type | output | 3 | 0 shared data, 1 exclusive data, 2 forwarded read, 3 forwarded read-exclusive, 4 invalidate, 5 acknowledge |
| msg_dst | output | CW | Destination cluster |
| msg_aux | output | CW | Requester named in a forwarded request |
| msg_addr | output | AW | Entry index of the message |
| msg_cnt | output | CNTW | Acknowledgements to collect, valid on exclusive data |

## Verification
Two functions can fall on the same edge. One is the taking of the last invalidate of a scan. The other is the reopening of the request port, with the next request held ready to be driven as soon as `req_ready` rises. The bench stalls each message for zero to two cycles. It drives the next request at the first idle point, so scan completion, backpressure and a fresh entry update follow each other closely. Every message's kind, destination, index and count is compared with a reference directory kept in the bench, and the bench confirms that nothing extra appears and that the port reopens.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHR = 2'd1,
    ST_DIR = 2'd2
  } dstate_e;

  typedef enum logic [2:0] {
    RQ_RD  = 3'd0,
    RQ_RDX = 3'd1,
    RQ_WB  = 3'd2,
    RQ_SWB = 3'd3,
    RQ_DXF = 3'd4
  } rkind_e;

  typedef enum logic [2:0] {
    MG_DSH = 3'd0,
    MG_DEX = 3'd1,
    MG_FRD = 3'd2,
    MG_FRX = 3'd3,
    MG_INV = 3'd4,
    MG_ACK = 3'd5
  } mkind_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_SEND = 2'd1,
    C_SCAN = 2'd2
  } cstate_e;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
  import dir_pkg::*;
#(
  parameter int NCLUST = 8,
  parameter int NENT   = 16,
  localparam int AW    = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output dstate_e           rd_state,
  output logic [NCLUST-1:0] rd_vec,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  dstate_e           wr_state,
  input  logic [NCLUST-1:0] wr_vec
);

  logic [NENT-1:0][1:0]        st_all;
  logic [NENT-1:0][NCLUST-1:0] vec_all;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic              hit;
    dstate_e           st_q;
    logic [NCLUST-1:0] vec_q;

    assign hit = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= ST_UNC;
        vec_q <= '0;
      end else if (hit) begin
        st_q  <= wr_state;
        vec_q <= wr_vec;
      end
    end

    assign st_all[g]  = st_q;
    assign vec_all[g] = vec_q;
  end

  assign rd_state = dstate_e'(st_all[rd_addr]);
  assign rd_vec   = vec_all[rd_addr];

endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import dir_pkg::*;
#(
  parameter int NCLUST = 8,
  parameter int HOME   = 0,
  localparam int CW    = (NCLUST > 1) ? $clog2(NCLUST) : 1,
  localparam int CNTW  = $clog2(NCLUST + 1)
) (
  input  logic [2:0]        req_type,
  input  logic [CW-1:0]     src,
  input  logic [CW-1:0]     aux,
  input  dstate_e           cur_state,
  input  logic [NCLUST-1:0] cur_vec,
  output logic              upd,
  output dstate_e           nx_state,
  output logic [NCLUST-1:0] nx_vec,
  output logic              has_msg,
  output mkind_e            m_type,
  output logic [CW-1:0]     m_dst,
  output logic [CW-1:0]     m_aux,
  output logic [CNTW-1:0]   m_cnt,
  output logic [NCLUST-1:0] inv_mask
);

  localparam logic [CW-1:0]     HOME_ID = CW'(HOME);
  localparam logic [NCLUST-1:0] ONE     = NCLUST'(1);

  function automatic logic [CNTW-1:0] count_ones(input logic [NCLUST-1:0] v);
    logic [CNTW-1:0] n;
    n = '0;
    for (int i = 0; i < NCLUST; i++) n = n + CNTW'(v[i]);
    return n;
  endfunction

  function automatic logic [CW-1:0] low_idx(input logic [NCLUST-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCLUST - 1; i >= 0; i--) if (v[i]) r = CW'(i);
    return r;
  endfunction

  logic              src_home, aux_home, owner_ok;
  logic [NCLUST-1:0] src_bit, aux_bit, sharers;
  logic [CW-1:0]     owner;

  assign src_home = (src == HOME_ID);
  assign aux_home = (aux == HOME_ID);
  assign src_bit  = ONE << src;
  assign aux_bit  = ONE << aux;
  assign owner    = low_idx(cur_vec);
  assign owner_ok = (cur_state == ST_DIR) && cur_vec[src];
  assign sharers  = cur_vec & ~src_bit;

  always_comb begin
    upd      = 1'b0;
    nx_state = cur_state;
    nx_vec   = cur_vec;
    has_msg  = 1'b0;
    m_type   = MG_DSH;
    m_dst    = src;
    m_aux    = src;
    m_cnt    = '0;
    inv_mask = '0;
    case (rkind_e'(req_type))
      RQ_RD: begin
        has_msg = 1'b1;
        if (cur_state == ST_DIR) begin
          m_type = MG_FRD;
          m_dst  = owner;
        end else if (!src_home) begin
          upd      = 1'b1;
          nx_state = ST_SHR;
          nx_vec   = cur_vec | src_bit;
        end
      end
      RQ_RDX: begin
        has_msg = 1'b1;
        m_type  = MG_DEX;
        if (cur_state == ST_DIR) begin
          m_type = MG_FRX;
          m_dst  = owner;
        end else begin
          if (cur_state == ST_SHR) begin
            inv_mask = sharers;
            m_cnt    = count_ones(sharers);
          end
          upd      = 1'b1;
          nx_state = src_home ? ST_UNC : ST_DIR;
          nx_vec   = src_home ? '0 : src_bit;
        end
      end
      RQ_WB: begin
        if (owner_ok) begin
          upd      = 1'b1;
          nx_state = ST_UNC;
          nx_vec   = '0;
        end
      end
      RQ_SWB: begin
        if (owner_ok) begin
          upd      = 1'b1;
          nx_state = ST_SHR;
          nx_vec   = cur_vec | (aux_home ? '0 : aux_bit);
        end
      end
      RQ_DXF: begin
        if (owner_ok) begin
          upd      = 1'b1;
          has_msg  = 1'b1;
          m_type   = MG_ACK;
          m_dst    = aux;
          nx_state = aux_home ? ST_UNC : ST_DIR;
          nx_vec   = aux_home ? '0 : aux_bit;
        end
      end
      default: begin
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dir_inv_scan.sv
module dir_inv_scan #(
  parameter int NCLUST = 8,
  localparam int CW    = (NCLUST > 1) ? $clog2(NCLUST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCLUST-1:0] load_mask,
  input  logic              take,
  output logic              pending,
  output logic              more,
  output logic [CW-1:0]     lo_idx
);

  logic [NCLUST-1:0] mask_q, mask_d, lowbit, rest;
  logic              mask_en;

  assign lowbit  = mask_q & (~mask_q + NCLUST'(1));
  assign rest    = mask_q & ~lowbit;
  assign pending = |mask_q;
  assign more    = |rest;
  assign mask_en = load | take;

  always_comb begin
    mask_d = mask_q;
    if (load)      mask_d = load_mask;
    else if (take) mask_d = rest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  for (genvar b = 0; b < CW; b++) begin : g_enc
    logic [NCLUST-1:0] sel;
    for (genvar i = 0; i < NCLUST; i++) begin : g_sel
      assign sel[i] = ((i >> b) & 1) == 1;
    end
    assign lo_idx[b] = |(lowbit & sel);
  end

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NCLUST = 8,
  parameter int NENT   = 16,
  parameter int HOME   = 0,
  localparam int CW    = (NCLUST > 1) ? $clog2(NCLUST) : 1,
  localparam int AW    = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CNTW  = $clog2(NCLUST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_type,
  input  logic [CW-1:0]   req_src,
  input  logic [CW-1:0]   req_aux,
  input  logic [AW-1:0]   req_addr,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [2:0]      msg_type,
  output logic [CW-1:0]   msg_dst,
  output logic [CW-1:0]   msg_aux,
  output logic [AW-1:0]   msg_addr,
  output logic [CNTW-1:0] msg_cnt
);

  logic rst_meta, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  cstate_e           st_q, st_d;
  dstate_e           e_state, p_state;
  logic [NCLUST-1:0] e_vec, p_vec, p_inv;
  logic              p_upd, p_has;
  mkind_e            p_type;
  logic [CW-1:0]     p_dst, p_aux;
  logic [CNTW-1:0]   p_cnt;
  logic              accept, in_send, in_scan, take;
  logic              scan_pend, scan_more;
  logic [CW-1:0]     scan_idx;

  logic [2:0]        mtype_q;
  logic [CW-1:0]     mdst_q, maux_q;
  logic [AW-1:0]     maddr_q;
  logic [CNTW-1:0]   mcnt_q;

  assign req_ready = (st_q == C_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_send   = (st_q == C_SEND);
  assign in_scan   = (st_q == C_SCAN);
  assign take      = in_scan && msg_ready;

  dir_entry_store #(.NCLUST(NCLUST), .NENT(NENT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_addr  (req_addr),
    .rd_state (e_state),
    .rd_vec   (e_vec),
    .wr_en    (accept && p_upd),
    .wr_addr  (req_addr),
    .wr_state (p_state),
    .wr_vec   (p_vec)
  );

  dir_policy #(.NCLUST(NCLUST), .HOME(HOME)) u_policy (
    .req_type  (req_type),
    .src       (req_src),
    .aux       (req_aux),
    .cur_state (e_state),
    .cur_vec   (e_vec),
    .upd       (p_upd),
    .nx_state  (p_state),
    .nx_vec    (p_vec),
    .has_msg   (p_has),
    .m_type    (p_type),
    .m_dst     (p_dst),
    .m_aux     (p_aux),
    .m_cnt     (p_cnt),
    .inv_mask  (p_inv)
  );

  dir_inv_scan #(.NCLUST(NCLUST)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (accept),
    .load_mask (p_inv),
    .take      (take),
    .pending   (scan_pend),
    .more      (scan_more),
    .lo_idx    (scan_idx)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      C_IDLE: if (accept && p_has) st_d = C_SEND;
      C_SEND: if (msg_ready) st_d = scan_pend ? C_SCAN : C_IDLE;
      C_SCAN: if (msg_ready && !scan_more) st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= C_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mtype_q <= '0;
      mdst_q  <= '0;
      maux_q  <= '0;
      maddr_q <= '0;
      mcnt_q  <= '0;
    end else if (accept) begin
      mtype_q <= p_type;
      mdst_q  <= p_dst;
      maux_q  <= p_aux;
      maddr_q <= req_addr;
      mcnt_q  <= p_cnt;
    end
  end

  assign msg_valid = in_send | in_scan;
  assign msg_type  = in_scan ? MG_INV : mtype_q;
  assign msg_dst   = in_scan ? scan_idx : mdst_q;
  assign msg_cnt   = in_scan ? '0 : mcnt_q;
  assign msg_aux   = maux_q;
  assign msg_addr  = maddr_q;

endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NCLUST = 8,
  parameter int NENT   = 16,
  parameter int HOME   = 0,
  localparam int CW    = (NCLUST > 1) ? $clog2(NCLUST) : 1,
  localparam int AW    = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CNTW  = $clog2(NCLUST + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_type,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [2:0]      msg_type,
  input logic [CW-1:0]   msg_dst,
  input logic [CW-1:0]   msg_aux,
  input logic [AW-1:0]   msg_addr,
  input logic [CNTW-1:0] msg_cnt
);

  localparam logic [CW-1:0]   HOME_ID = CW'(HOME);
  localparam logic [CNTW-1:0] MAXC    = CNTW'(NCLUST - 1);

  logic          inv_seen;
  logic [CW-1:0] inv_last;
  logic          hs;

  assign hs = msg_valid && msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_seen <= 1'b0;
      inv_last <= '0;
    end else if (hs) begin
      inv_seen <= (msg_type == 3'd4);
      inv_last <= msg_dst;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!msg_valid); // R1
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_type) && $stable(msg_dst)
      && $stable(msg_aux) && $stable(msg_addr) && $stable(msg_cnt)); // R10

  AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready); // R10

  AST_WB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_type == 3'd2 |=> !msg_valid); // R9

  AST_SWB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_type == 3'd3 |=> !msg_valid); // R4

  AST_INV_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    hs && msg_type == 3'd4 && inv_seen |-> msg_dst > inv_last); // R6

  AST_INV_NOT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd4 |-> msg_dst != HOME_ID); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_type == 3'd1 |-> msg_cnt <= MAXC); // R6

endmodule

bind dir_ctrl dir_ctrl_chk #(.NCLUST(NCLUST), .NENT(NENT), .HOME(HOME)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_type  (req_type),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_type  (msg_type),
  .msg_dst   (msg_dst),
  .msg_aux   (msg_aux),
  .msg_addr  (msg_addr),
  .msg_cnt   (msg_cnt)
);

// File: tb/sim_dir_ctrl.sv
`timescale 1ns/1ps
module sim_dir_ctrl;

  localparam int NC = 4;
  localparam int NE = 4;
  localparam int HM = 0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, msg_valid, msg_ready;
  logic [2:0] req_type, msg_type;
  logic [1:0] req_src, req_aux, req_addr, msg_dst, msg_aux, msg_addr;
  logic [2:0] msg_cnt;

  always #2 clk = ~clk;

  dir_ctrl #(.NCLUST(NC), .NENT(NE), .HOME(HM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_src(req_src), .req_aux(req_aux), .req_addr(req_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
    .msg_dst(msg_dst), .msg_aux(msg_aux), .msg_addr(msg_addr), .msg_cnt(msg_cnt)
  );

  int n_checks = 0;
  int n_errors = 0;
  int n_req    = 0;
  bit done     = 0;

  int         m_st  [NE];
  logic [3:0] m_vec [NE];
  int         e_type[8], e_dst[8], e_aux[8], e_cnt[8];
  int         n_exp;
  string      m_tag;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int t, input int d, input int x, input int c);
    e_type[n_exp] = t; e_dst[n_exp] = d; e_aux[n_exp] = x; e_cnt[n_exp] = c;
    n_exp++;
  endtask

  task automatic model(input int t, input int s, input int a, input int x);
    int   own;
    bit   ok;
    logic [3:0] sh;
    int   n;
    own = 0;
    for (int i = NC - 1; i >= 0; i--) if (m_vec[a][i]) own = i;
    ok = (m_st[a] == 2) && m_vec[a][s];
    n_exp = 0;
    m_tag = "R9";
    case (t)
      0: if (m_st[a] == 2) begin
           push(2, own, s, 0); m_tag = "R3";
         end else begin
           push(0, s, s, 0); m_tag = "R2";
           if (s != HM) begin m_st[a] = 1; m_vec[a][s] = 1'b1; end
         end
      1: if (m_st[a] == 2) begin
           push(3, own, s, 0); m_tag = "R7";
         end else begin
           sh = (m_st[a] == 1) ? (m_vec[a] & ~(4'd1 << s)) : 4'd0;
           n = 0;
           for (int i = 0; i < NC; i++) n += int'(sh[i]);
           push(1, s, s, n);
           for (int i = 0; i < NC; i++) if (sh[i]) push(4, i, s, 0);
           if (m_st[a] == 1) m_tag = "R6";
           else m_tag = (s == HM) ? "R8" : "R5";
           if (s == HM) begin m_st[a] = 0; m_vec[a] = 4'd0; end
           else begin m_st[a] = 2; m_vec[a] = 4'd1 << s; end
         end
      2: if (ok) begin m_st[a] = 0; m_vec[a] = 4'd0; end
      3: begin
           m_tag = "R4";
           if (ok) begin
             m_st[a] = 1;
             if (x != HM) m_vec[a][x] = 1'b1;
           end
         end
      4: if (ok) begin
           push(5, x, s, 0); m_tag = "R7";
           if (x == HM) begin m_st[a] = 0; m_vec[a] = 4'd0; end
           else begin m_st[a] = 2; m_vec[a] = 4'd1 << x; end
         end
      default: m_tag = "R9";
    endcase
  endtask

  task automatic do_req(input int t, input int s, input int a, input int x,
                        input string force_tag);
    model(t, s, a, x);
    if (force_tag != "") m_tag = force_tag;
    check(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_type  = 3'(t);
    req_src   = 2'(s);
    req_aux   = 2'(x);
    req_addr  = 2'(a);
    @(negedge clk);
    req_valid = 1'b0;
    if (n_exp > 0)
      check(req_ready == 1'b0, "R10", "ready while busy", int'(req_ready), 0);
    for (int i = 0; i < n_exp; i++) begin
      for (int d = 0; d < (n_req + i) % 3; d++) begin
        msg_ready = 1'b0;
        @(negedge clk);
      end
      check(msg_valid == 1'b1, m_tag, "msg_valid", int'(msg_valid), 1);
      check(int'(msg_type) == e_type[i], m_tag, "msg_type", int'(msg_type), e_type[i]);
      check(int'(msg_dst) == e_dst[i], m_tag, "msg_dst", int'(msg_dst), e_dst[i]);
      check(int'(msg_addr) == a, m_tag, "msg_addr", int'(msg_addr), a);
      if (e_type[i] == 1)
        check(int'(msg_cnt) == e_cnt[i], m_tag, "msg_cnt", int'(msg_cnt), e_cnt[i]);
      if (e_type[i] == 2 || e_type[i] == 3)
        check(int'(msg_aux) == e_aux[i], m_tag, "msg_aux", int'(msg_aux), e_aux[i]);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
    check(msg_valid == 1'b0, (n_exp > 0) ? "R10" : m_tag, "no further message",
          int'(msg_valid), 0);
    n_req++;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; req_valid = 1'b0; msg_ready = 1'b0;
    req_type = '0; req_src = '0; req_aux = '0; req_addr = '0;
    for (int e = 0; e < NE; e++) begin m_st[e] = 0; m_vec[e] = 4'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(msg_valid == 1'b0, "R1", "msg_valid after reset", int'(msg_valid), 0);
    // R1: every entry must answer a remote read as uncached
    for (int e = 0; e < NE; e++) do_req(0, 1, e, 0, "R1");
    lfsr = 16'hACE1;
    for (int p = 0; p < 40; p++)
      for (int t = 0; t < 6; t++)
        for (int s = 0; s < NC; s++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          do_req(t, s, int'(lfsr[1:0]), int'(lfsr[3:2]), "");
        end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule